// File: doc/BRIEF.md
# USB Host Interrupt Aggregator with Threshold Deferral

This block gathers six interrupt events of a USB host controller into one interrupt line. Each event source has its own sticky status bit and its own enable bit. Software reads and writes both registers through a simple register port. It acknowledges an event by writing a one to the matching status bit, which clears it.

The sources fall into two classes. Host system error, frame list rollover and port change are urgent. They drive the interrupt line as soon as the status bit and the enable bit are both set. Transfer completion, transfer error and async advance are deferred. They reach the line only after the next pulse on the threshold tick input, so that several completions can share one interrupt. A deferred source that has been signalled keeps the line asserted until its status bit is cleared or its enable bit is dropped.

Top module: `irqAggregator`

## Requirements
- R1: After reset, every status bit and every enable bit reads zero and `irqOut` is low.
- R2: `regAddr`=1 selects the enable register. Bits 5:0 are read/write with this map: bit 0 transfer completion, bit 1 transfer error, bit 2 port change, bit 3 frame list rollover, bit 4 host system error, bit 5 async advance. Bits 31:6 read as zero and ignore writes.
- R3: `regAddr`=0 selects the status register, which uses the same bit map. A one-cycle pulse on `evtIn[i]` sets status bit i from the next cycle on, and the bit then stays set.
- R4: A write to status with bit i of `regWrData` set clears status bit i from the next cycle on. Bits written as zero are unchanged. Status bits 31:6 read as zero and ignore writes.
- R5: If an event on bit i arrives in the same cycle as a clear of bit i, the event wins and the bit stays set.
- R6: For the immediate sources (bits 2, 3, 4), `irqOut` is high in the cycle after the status bit and the enable bit are both set.
- R7: For the deferred sources (bits 0, 1, 5), setting the status bit and the enable bit does not raise `irqOut`. `irqOut` rises in the cycle after a `thresholdTick` pulse during which the bit is set and enabled.
- R8: A signalled deferred source holds `irqOut` high until its status bit is cleared or its enable bit is written to zero. If the enable bit is set again, a fresh tick is needed before `irqOut` rises.
- R9: `irqOut` is the OR of all enabled immediate status bits and all signalled deferred sources. A source that is not enabled never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 6 | One-cycle event pulses, one per source |
| thresholdTick | input | 1 | Interrupt threshold boundary pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = status, 1 = enable |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the register selected by `regAddr` |
| irqOut | output | 1 | Aggregated interrupt |

## Verification
Every source is swept both enabled and disabled. Each run has an event, then a threshold tick, then an acknowledge, and `irqOut` is checked after every step. Only this sweep tells apart the immediate class, which fires right after the event, from the deferred class, which fires only after the tick. A collision of an event and a clear in the same cycle shows that the event takes priority. Dropping the enable of a signalled deferred source, and then restoring it with and without a new tick, shows that the signalled flag is discarded. Writes of all ones to both registers show that the reserved bits stay zero.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NUM_SRC = 6;
  localparam int DATA_W  = 32;
  // Sources that signal at once; the rest wait for a threshold tick.
  localparam logic [NUM_SRC-1:0] IMM_MASK = 6'b011100;
  localparam logic [NUM_SRC-1:0] DEF_MASK = ~IMM_MASK;

  typedef struct packed {
    logic clrStatus;
    logic loadEnable;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic         regWrEn,
  input  logic         regAddr,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clrStatus  = regWrEn && (regAddr == 1'b0);
    strobes.loadEnable = regWrEn && (regAddr == 1'b1);
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               thresholdTick,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] statusQ, statusD;
  logic [NUM_SRC-1:0] enableQ, enableD;
  logic [NUM_SRC-1:0] pendQ,   pendD;
  logic [NUM_SRC-1:0] clrMask;

  always_comb begin
    clrMask = strobes.clrStatus ? regWrData[NUM_SRC-1:0] : '0;
    statusD = (statusQ & ~clrMask) | evtIn;
    enableD = strobes.loadEnable ? regWrData[NUM_SRC-1:0] : enableQ;
    pendD   = statusD & enableD & DEF_MASK & (pendQ | {NUM_SRC{thresholdTick}});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      pendQ   <= '0;
    end else begin
      statusQ <= statusD;
      enableQ <= enableD;
      pendQ   <= pendD;
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[NUM_SRC-1:0] = regAddr ? enableQ : statusQ;
  end

  assign irqOut = (|(statusQ & enableQ & IMM_MASK)) | (|pendQ);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((statusQ & $past(evtIn)) == $past(evtIn))); // R3
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && evtIn == '0) |=> ((statusQ & $past(regWrData[NUM_SRC-1:0])) == '0)); // R4
  AST_PEND_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0 && !thresholdTick) |=> (pendQ == '0)); // R7
  AST_PEND_DEFERRED_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~(statusQ & enableQ & DEF_MASK)) == '0)); // R8
  AST_IMM_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & enableQ & IMM_MASK) != '0) |-> irqOut); // R6
  always_comb begin
    AST_RSV_ZERO: assert (regRdData[DATA_W-1:NUM_SRC] == '0); // R2
  end
endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               thresholdTick,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  ctrlStrobes_t strobes;

  irqControl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irqDatapath uData (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .evtIn         (evtIn),
    .thresholdTick (thresholdTick),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .irqOut        (irqOut)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !irqOut); // R1
endmodule

// File: tb/irqAggregator_test.sv
module irqAggregator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  evtIn = '0;
  logic        thresholdTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  int total = 0;
  int bad = 0;

  localparam logic [5:0] IMM = 6'b011100;

  always #5 clk = ~clk;

  irqAggregator uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .thresholdTick(thresholdTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] e, input logic t, input logic w,
                      input logic a, input logic [31:0] d);
    evtIn = e; thresholdTick = t; regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    evtIn = '0; thresholdTick = 0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic readReg(input logic a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(regRdData, exp, tag);
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk({31'd0, irqOut}, 0, "R1 irq");
    readReg(0, 0, "R1 status");
    readReg(1, 0, "R1 enable");

    // R2 reserved enable bits
    step(0, 0, 1, 1, 32'hFFFF_FFFF);
    readReg(1, 32'h3F, "R2 enable rw");
    step(0, 0, 1, 1, 32'hFFFF_FFC0);
    readReg(1, 0, "R2 reserved ignored");

    // R3 R6 R7 R8 R9 sweep over each source, enabled and disabled
    for (int s = 0; s < 6; s++) begin
      for (int en = 0; en < 2; en++) begin
        logic [5:0] b;
        logic imm;
        b = 6'(1 << s);
        imm = IMM[s];
        step(0, 0, 1, 1, en ? {26'd0, b} : 32'd0);
        step(b, 0, 0, 0, 0);
        readReg(0, {26'd0, b}, "R3 status set");
        chk({31'd0, irqOut}, (en && imm) ? 1 : 0, imm ? "R6 immediate" : "R7 deferred before tick");
        step(0, 0, 0, 0, 0);
        readReg(0, {26'd0, b}, "R3 status sticky");
        step(0, 1, 0, 0, 0);
        chk({31'd0, irqOut}, en ? 1 : 0, "R9 after tick");
        step(0, 0, 0, 0, 0);
        chk({31'd0, irqOut}, en ? 1 : 0, "R8 held");
        step(0, 0, 1, 0, {26'd0, b});
        readReg(0, 0, "R4 cleared");
        chk({31'd0, irqOut}, 0, "R8 released on clear");
      end
    end

    // R4 writing zeros leaves bits; reserved status writes ignored
    step(0, 0, 1, 1, 0);
    step(6'h3F, 0, 0, 0, 0);
    step(0, 0, 1, 0, 32'hFFFF_FFC0);
    readReg(0, 32'h3F, "R4 zero write keeps");
    step(0, 0, 1, 0, 32'h0000_0005);
    readReg(0, 32'h3A, "R4 partial clear");

    // R5 event and clear same cycle
    step(6'h02, 0, 1, 0, 32'h0000_0002);
    readReg(0, 32'h3A, "R5 event wins");
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    readReg(0, 0, "R4 clear all");

    // R8 enable drop on deferred source, then re-enable
    step(0, 0, 1, 1, 32'h20);
    step(6'h20, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk({31'd0, irqOut}, 1, "R7 async after tick");
    step(0, 0, 1, 1, 0);
    chk({31'd0, irqOut}, 0, "R8 enable drop");
    step(0, 0, 1, 1, 32'h20);
    chk({31'd0, irqOut}, 0, "R8 reenable needs tick");
    step(0, 1, 0, 0, 0);
    chk({31'd0, irqOut}, 1, "R8 new tick");

    // R9 disabled immediate never fires, mixed OR
    step(0, 0, 1, 1, 32'h21);
    step(6'h10, 0, 0, 0, 0);
    chk({31'd0, irqOut}, 1, "R9 deferred still signalled");
    step(0, 0, 1, 0, 32'h20);
    chk({31'd0, irqOut}, 0, "R9 disabled host error silent");
    step(0, 0, 1, 1, 32'h10);
    chk({31'd0, irqOut}, 1, "R6 enable after status");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule